// File: doc/BRIEF.md
# Phase Configuration History Table

This block remembers, per execution phase, the best cache configuration that the tuner has found so far, and returns it when that phase runs again. A phase is presented by its raw instruction-cache and data-cache miss rates. The first phase seen after reset becomes the reference. Every phase, including that first one, is scaled against the reference and sorted into coarse similarity buckets. The pair of bucket indices forms the search key, so neighbouring phases share one stored result.

Each stored entry holds a valid flag, the key, the optimisation goal it was tuned for, and a packed configuration (log2 size code, log2 ways, log2 line code). A lookup answers one cycle later with hit or miss, the key it computed and, on a hit, the stored configuration. On a miss the tuner explores configurations and writes the outcome back through the update port. For an existing entry it also signals whether the new configuration beats the stored one under the active goal.

Top module: `phase_history_table`

## Requirements
- R1: After reset no response is valid and the table holds no entries, so every lookup misses until an update is made.
- R2: The rates of the first lookup after reset become the reference. That lookup is scaled against its own rates, so both of its buckets equal 10 and its key is 8'hAA.
- R3: For each cache, norm = floor(rate*100/ref) and bucket = floor(norm/10), saturated at 15. A zero reference rate gives bucket 15.
- R4: The key is {instruction bucket, data bucket}, with the instruction bucket in bits [7:4] and the data bucket in bits [3:0].
- R5: A lookup request presented at one clock edge is answered by rsp_valid_o in the following cycle. rsp_valid_o is low in any cycle that follows no request.
- R6: A lookup hits only when the key and the 2-bit goal tag both match a valid entry. The goal codes are 0 = energy-delay product, 1 = energy and 2 = execution time.
- R7: On a hit rsp_cfg_o carries the stored configuration, and on a miss it is zero. The configuration is packed as {size[6:4], ways[3:2], line[1:0]}.
- R8: An update whose key and goal match no entry allocates a slot, whatever the better flag says. Slots fill in order, and once all 16 are used the least recently allocated slot is replaced.
- R9: An update whose key and goal match an entry replaces its configuration only when upd_better_i is high. Otherwise it has no effect.
- R10: A lookup made in the same cycle as an update sees the table as it was before that update.
- R11: The reference rates are kept until the next reset. Later lookups never change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_imiss_i | input | 16 | Instruction-cache miss rate of the phase |
| lk_dmiss_i | input | 16 | Data-cache miss rate of the phase |
| lk_prio_i | input | 2 | Active optimisation goal for the lookup |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_hit_o | output | 1 | Entry found |
| rsp_key_o | output | 8 | Bucket key computed for the request |
| rsp_cfg_o | output | 7 | Stored configuration, zero on a miss |
| upd_valid_i | input | 1 | Write or update request from the tuner |
| upd_key_i | input | 8 | Key of the entry to write |
| upd_prio_i | input | 2 | Goal tag of the entry to write |
| upd_cfg_i | input | 7 | Configuration to store |
| upd_better_i | input | 1 | The new configuration improves on the stored one |

## Verification
The bench targets the bucket edges: 149 versus 150 scaled units, values that saturate, and a zero reference. Wrong rounding or a missing clamp would move a phase into another bucket and give a wrong key. It checks that a goal mismatch misses and that an update without the better flag leaves the stored value alone. A design that ignored the goal tag or the flag would return a wrong or overwritten configuration. It fills the table and then checks that replacement removes the oldest allocation rather than a recent one. It also checks that a lookup in the same cycle as an update returns the old contents, and that reset empties the table and clears the reference.

// File: rtl/phase_tbl_pkg.sv
package phase_tbl_pkg;
  localparam int NUM_GOALS = 3;
  localparam int PRIO_W    = $clog2(NUM_GOALS);

  typedef enum logic [PRIO_W-1:0] {
    GOAL_EDP    = 2'd0,
    GOAL_ENERGY = 2'd1,
    GOAL_TIME   = 2'd2
  } goal_e;

  typedef struct packed {
    logic [2:0] size_log;
    logic [1:0] ways_log;
    logic [1:0] line_log;
  } cache_cfg_t;

  localparam int CFG_W = $bits(cache_cfg_t);
endpackage

// File: rtl/phase_bucketizer.sv
module phase_bucketizer #(
  parameter int RATE_W = 16,
  parameter int SCALE  = 100,
  parameter int THRESH = 10,
  parameter int BKT_W  = 4
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic [RATE_W-1:0] ref_i,
  output logic [BKT_W-1:0]  bucket_o
);
  localparam int PROD_W = RATE_W + $clog2(SCALE + 1);
  localparam logic [PROD_W-1:0] BKT_MAX = PROD_W'((1 << BKT_W) - 1);

  logic [PROD_W-1:0] prod, norm, bkt_full;

  always_comb begin
    prod     = PROD_W'(rate_i) * PROD_W'(SCALE);
    norm     = '0;
    bkt_full = BKT_MAX;
    if (ref_i != '0) begin
      norm     = prod / PROD_W'(ref_i);
      bkt_full = norm / PROD_W'(THRESH);
    end
    if (bkt_full > BKT_MAX) bucket_o = BKT_MAX[BKT_W-1:0];
    else                    bucket_o = bkt_full[BKT_W-1:0];
  end
endmodule

// File: rtl/phase_tbl_store.sv
module phase_tbl_store #(
  parameter int N_ENT  = 16,
  parameter int KEY_W  = 8,
  parameter int PRIO_W = 2,
  parameter int CFG_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [KEY_W-1:0]  lk_key_i,
  input  logic [PRIO_W-1:0] lk_prio_i,
  output logic              lk_hit_o,
  output logic [CFG_W-1:0]  lk_cfg_o,
  input  logic              upd_valid_i,
  input  logic [KEY_W-1:0]  upd_key_i,
  input  logic [PRIO_W-1:0] upd_prio_i,
  input  logic [CFG_W-1:0]  upd_cfg_i,
  input  logic              upd_better_i
);
  localparam int IDX_W = $clog2(N_ENT);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  logic [N_ENT-1:0]  valid_q;
  logic [KEY_W-1:0]  key_q  [N_ENT];
  logic [PRIO_W-1:0] prio_q [N_ENT];
  logic [CFG_W-1:0]  cfg_q  [N_ENT];
  logic [IDX_W-1:0]  ptr_q;

  logic [N_ENT-1:0]  lk_match, up_match;
  logic [IDX_W-1:0]  lk_idx, upd_idx;
  logic              upd_hit, alloc;
  logic [CFG_W-1:0]  upd_old_cfg;

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    assign lk_match[e] = valid_q[e] && key_q[e] == lk_key_i  && prio_q[e] == lk_prio_i;
    assign up_match[e] = valid_q[e] && key_q[e] == upd_key_i && prio_q[e] == upd_prio_i;
  end

  always_comb begin
    lk_idx  = '0;
    upd_idx = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (lk_match[e]) lk_idx  = IDX_W'(e);
      if (up_match[e]) upd_idx = IDX_W'(e);
    end
  end

  assign lk_hit_o    = |lk_match;
  assign lk_cfg_o    = lk_hit_o ? cfg_q[lk_idx] : '0;
  assign upd_hit     = |up_match;
  assign alloc       = upd_valid_i && !upd_hit;
  assign upd_old_cfg = cfg_q[upd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
      for (int e = 0; e < N_ENT; e++) begin
        key_q[e]  <= '0;
        prio_q[e] <= '0;
        cfg_q[e]  <= '0;
      end
    end else if (alloc) begin
      valid_q[ptr_q] <= 1'b1;
      key_q[ptr_q]   <= upd_key_i;
      prio_q[ptr_q]  <= upd_prio_i;
      cfg_q[ptr_q]   <= upd_cfg_i;
      ptr_q          <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end else if (upd_valid_i && upd_better_i) begin
      cfg_q[upd_idx] <= upd_cfg_i;
    end
  end

  assert_single_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));
  assert_alloc_fills_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc |=> valid_q[$past(ptr_q)] && key_q[$past(ptr_q)] == $past(upd_key_i));
  assert_keep_unless_better_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_hit && !upd_better_i) |=> cfg_q[$past(upd_idx)] == $past(upd_old_cfg));
endmodule

// File: rtl/phase_history_table.sv
module phase_history_table
  import phase_tbl_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int BKT_W  = 4,
  parameter int N_ENT  = 16,
  parameter int SCALE  = 100,
  parameter int THRESH = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lk_valid_i,
  input  logic [RATE_W-1:0]     lk_imiss_i,
  input  logic [RATE_W-1:0]     lk_dmiss_i,
  input  logic [PRIO_W-1:0]     lk_prio_i,
  output logic                  rsp_valid_o,
  output logic                  rsp_hit_o,
  output logic [2*BKT_W-1:0]    rsp_key_o,
  output logic [CFG_W-1:0]      rsp_cfg_o,
  input  logic                  upd_valid_i,
  input  logic [2*BKT_W-1:0]    upd_key_i,
  input  logic [PRIO_W-1:0]     upd_prio_i,
  input  logic [CFG_W-1:0]      upd_cfg_i,
  input  logic                  upd_better_i
);
  localparam int KEY_W = 2 * BKT_W;
  localparam int N_SRC = 2;

  logic                ref_valid_q;
  logic [RATE_W-1:0]   ref_q   [N_SRC];
  logic [RATE_W-1:0]   rate_a  [N_SRC];
  logic [RATE_W-1:0]   ref_eff [N_SRC];
  logic [BKT_W-1:0]    bkt_a   [N_SRC];
  logic [KEY_W-1:0]    lk_key;
  logic                tbl_hit;
  logic [CFG_W-1:0]    tbl_cfg;

  assign rate_a[0] = lk_imiss_i;
  assign rate_a[1] = lk_dmiss_i;

  for (genvar c = 0; c < N_SRC; c++) begin : g_src
    assign ref_eff[c] = ref_valid_q ? ref_q[c] : rate_a[c];
    phase_bucketizer #(
      .RATE_W (RATE_W),
      .SCALE  (SCALE),
      .THRESH (THRESH),
      .BKT_W  (BKT_W)
    ) u_bkt (
      .rate_i   (rate_a[c]),
      .ref_i    (ref_eff[c]),
      .bucket_o (bkt_a[c])
    );
  end

  assign lk_key = {bkt_a[0], bkt_a[1]};

  phase_tbl_store #(
    .N_ENT  (N_ENT),
    .KEY_W  (KEY_W),
    .PRIO_W (PRIO_W),
    .CFG_W  (CFG_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_key_i     (lk_key),
    .lk_prio_i    (lk_prio_i),
    .lk_hit_o     (tbl_hit),
    .lk_cfg_o     (tbl_cfg),
    .upd_valid_i  (upd_valid_i),
    .upd_key_i    (upd_key_i),
    .upd_prio_i   (upd_prio_i),
    .upd_cfg_i    (upd_cfg_i),
    .upd_better_i (upd_better_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_valid_q <= 1'b0;
      for (int c = 0; c < N_SRC; c++) ref_q[c] <= '0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_key_o   <= '0;
      rsp_cfg_o   <= '0;
    end else begin
      if (lk_valid_i && !ref_valid_q) begin
        ref_valid_q <= 1'b1;
        for (int c = 0; c < N_SRC; c++) ref_q[c] <= rate_a[c];
      end
      rsp_valid_o <= lk_valid_i;
      rsp_hit_o   <= lk_valid_i && tbl_hit;
      if (lk_valid_i) begin
        rsp_key_o <= lk_key;
        rsp_cfg_o <= tbl_hit ? tbl_cfg : '0;
      end
    end
  end

  assert_rsp_follows_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o);
  assert_no_spurious_rsp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !rsp_valid_o);
  assert_miss_cfg_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> rsp_cfg_o == '0);
  assert_zero_rate_bucket_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_imiss_i == '0 && ref_eff[0] != '0) |-> bkt_a[0] == '0);
  assert_ref_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_q |=> ref_valid_q && $stable(ref_q[0]) && $stable(ref_q[1]));
endmodule

// File: tb/sim_phase_history_table.sv
`timescale 1ns/1ps
module sim_phase_history_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_imiss = '0, lk_dmiss = '0;
  logic [1:0]  lk_prio = '0;
  logic        rsp_valid, rsp_hit;
  logic [7:0]  rsp_key;
  logic [6:0]  rsp_cfg;
  logic        upd_valid = 1'b0;
  logic [7:0]  upd_key = '0;
  logic [1:0]  upd_prio = '0;
  logic [6:0]  upd_cfg = '0;
  logic        upd_better = 1'b0;

  int applied = 0, failed = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phase_history_table u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_imiss_i(lk_imiss), .lk_dmiss_i(lk_dmiss), .lk_prio_i(lk_prio),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_key_o(rsp_key), .rsp_cfg_o(rsp_cfg),
    .upd_valid_i(upd_valid), .upd_key_i(upd_key), .upd_prio_i(upd_prio),
    .upd_cfg_i(upd_cfg), .upd_better_i(upd_better)
  );

  typedef struct packed {
    logic        is_upd;
    logic [15:0] imiss;
    logic [15:0] dmiss;
    logic [7:0]  key;
    logic [1:0]  prio;
    logic [6:0]  cfg;
    logic        better;
    logic        exp_hit;
    logic [6:0]  exp_cfg;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'd200,  16'd50, 8'hAA, 2'd0, 7'h00, 1'b0, 1'b0, 7'h00}, // R2 first phase, key AA
    '{1'b1, 16'd0,    16'd0,  8'hAA, 2'd0, 7'h25, 1'b0, 1'b0, 7'h00}, // R8 alloc without better
    '{1'b0, 16'd200,  16'd50, 8'hAA, 2'd0, 7'h00, 1'b0, 1'b1, 7'h25}, // R7 hit
    '{1'b0, 16'd200,  16'd50, 8'hAA, 2'd1, 7'h00, 1'b0, 1'b0, 7'h00}, // R6 goal mismatch
    '{1'b1, 16'd0,    16'd0,  8'hAA, 2'd0, 7'h11, 1'b0, 1'b0, 7'h00}, // R9 not better
    '{1'b0, 16'd200,  16'd50, 8'hAA, 2'd0, 7'h00, 1'b0, 1'b1, 7'h25}, // R9 kept
    '{1'b1, 16'd0,    16'd0,  8'hAA, 2'd0, 7'h33, 1'b1, 1'b0, 7'h00}, // R9 better
    '{1'b0, 16'd200,  16'd50, 8'hAA, 2'd0, 7'h00, 1'b0, 1'b1, 7'h33}, // R9 replaced
    '{1'b0, 16'd9,    16'd0,  8'h00, 2'd2, 7'h00, 1'b0, 1'b0, 7'h00}, // R3 low and zero rate
    '{1'b0, 16'd299,  16'd74, 8'hEE, 2'd0, 7'h00, 1'b0, 1'b0, 7'h00}, // R3 149/148 -> 14
    '{1'b0, 16'd2000, 16'd1,  8'hF0, 2'd0, 7'h00, 1'b0, 1'b0, 7'h00}, // R3 saturate, R4 order
    '{1'b0, 16'd219,  16'd54, 8'hAA, 2'd0, 7'h00, 1'b0, 1'b1, 7'h33}, // R11 similar phase shares
    '{1'b0, 16'd220,  16'd55, 8'hBB, 2'd0, 7'h00, 1'b0, 1'b0, 7'h00}  // R3 110 -> 11
  };

  task automatic chk(input bit ok, input string req, input string what);
    applied++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic lookup(input logic [15:0] im, input logic [15:0] dm, input logic [1:0] pr,
                        input logic [7:0] ekey, input logic ehit, input logic [6:0] ecfg,
                        input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_imiss = im; lk_dmiss = dm; lk_prio = pr;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid && rsp_hit == ehit && rsp_key == ekey && rsp_cfg == ecfg, req,
        $sformatf("valid=%0b hit=%0b key=%h cfg=%h, expected valid=1 hit=%0b key=%h cfg=%h",
                  rsp_valid, rsp_hit, rsp_key, rsp_cfg, ehit, ekey, ecfg));
  endtask

  task automatic update(input logic [7:0] k, input logic [1:0] pr, input logic [6:0] c,
                        input logic b);
    @(negedge clk);
    upd_valid = 1'b1; upd_key = k; upd_prio = pr; upd_cfg = c; upd_better = b;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", $sformatf("rsp_valid=%0b expected 0 in reset", rsp_valid));
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_upd) begin
        update(VEC[i].key, VEC[i].prio, VEC[i].cfg, VEC[i].better);
        chk(rsp_valid == 1'b0, "R5",
            $sformatf("vector %0d rsp_valid=%0b expected 0 without lookup", i, rsp_valid));
      end else begin
        lookup(VEC[i].imiss, VEC[i].dmiss, VEC[i].prio, VEC[i].key, VEC[i].exp_hit,
               VEC[i].exp_cfg, $sformatf("vector %0d (R2 R3 R4 R6 R7)", i));
      end
    end

    // R8: fill the remaining 15 slots, then evict in allocation order
    for (int k = 0; k < 15; k++) update(8'(k), 2'd2, 7'(k + 1), 1'b1);
    lookup(16'd200, 16'd50, 2'd0, 8'hAA, 1'b1, 7'h33, "R8 full, oldest still present");
    update(8'h20, 2'd2, 7'h50, 1'b0);
    lookup(16'd200, 16'd50, 2'd0, 8'hAA, 1'b0, 7'h00, "R8 oldest evicted");
    lookup(16'd9, 16'd0, 2'd2, 8'h00, 1'b1, 7'h01, "R8 second oldest kept");
    update(8'h21, 2'd2, 7'h51, 1'b0);
    lookup(16'd9, 16'd0, 2'd2, 8'h00, 1'b0, 7'h00, "R8 second oldest evicted");

    // R10: lookup and update in the same cycle
    @(negedge clk);
    lk_valid = 1'b1; lk_imiss = 16'd220; lk_dmiss = 16'd55; lk_prio = 2'd0;
    upd_valid = 1'b1; upd_key = 8'hBB; upd_prio = 2'd0; upd_cfg = 7'h44; upd_better = 1'b0;
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    chk(rsp_valid && !rsp_hit && rsp_key == 8'hBB && rsp_cfg == 7'h00, "R10",
        $sformatf("hit=%0b key=%h cfg=%h expected hit=0 key=bb cfg=00", rsp_hit, rsp_key, rsp_cfg));
    lookup(16'd220, 16'd55, 2'd0, 8'hBB, 1'b1, 7'h44, "R10 write visible next");

    // R1/R2/R3/R11 after a second reset with a zero instruction reference
    update(8'hFA, 2'd0, 7'h7F, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", $sformatf("rsp_valid=%0b expected 0 in reset", rsp_valid));
    rst_n = 1'b1;
    lookup(16'd0, 16'd5, 2'd0, 8'hFA, 1'b0, 7'h00, "R1 table cleared, R3 zero ref -> 15");
    lookup(16'd0, 16'd10, 2'd0, 8'hFF, 1'b0, 7'h00, "R11 reference kept");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end
endmodule